// File: doc/BRIEF.md
# Odd/Even Black-Level Clamp

This block sits after the digitizer of a linear image sensor readout. It sees every sample of a line, tagged with its 1-based position in the line. It builds two black references, one for odd positions and one for even positions. Each reference is the average of four masked (optical-black) samples of that parity near the start of the line.

Every effective pixel that follows has the black reference of its own parity subtracted. Odd and even pixels leave the sensor through separate paths and carry different offsets, so each parity needs its own correction. The difference between the two references is exposed so that firmware or a monitor can watch the parity imbalance. Leading dummy and masked samples, and trailing dummy samples, are consumed and not forwarded.

Top module: `parity_black_clamp`

## Requirements
- R1: After reset, out_valid, out_pixel, black_odd, black_even and black_diff are all zero.
- R2: black_even becomes floor((S8+S10+S12+S14)/4), where Sn is the valid sample whose in_index equals n.
- R3: black_odd becomes floor((S7+S9+S11+S13)/4), taken from the valid samples at indices 7, 9, 11 and 13 of the same line.
- R4: Both references change only on the clock edge that captures a valid sample at index 14. The new values are visible one cycle after that sample, and they hold their value through all other cycles.
- R5: black_diff equals black_odd minus black_even as a (DATA_W+1)-bit two's-complement value.
- R6: A valid sample at an index from 99 to 4016 appears one cycle later with out_valid high. Its out_pixel is the sample minus black_odd when the index is odd, and the sample minus black_even when the index is even.
- R7: When the sample is below the reference of its parity, out_pixel is 0 and does not wrap.
- R8: Samples at indices 1 to 98 or above 4016, and cycles with in_valid low, produce out_valid low on the next cycle.
- R9: A sample with in_valid low has no effect on either reference, even when its index is 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample qualifier |
| in_index | input | IDX_W (12) | 1-based position of the sample in the line |
| in_sample | input | DATA_W (12) | Digitized sample value |
| out_valid | output | 1 | Corrected effective pixel present |
| out_pixel | output | DATA_W (12) | Black-corrected pixel value |
| black_odd | output | DATA_W (12) | Odd-parity black reference |
| black_even | output | DATA_W (12) | Even-parity black reference |
| black_diff | output | DATA_W+1 (13) | Odd reference minus even reference, signed |

## Verification
Two cases are hard to reach from the ports. The first is a reference that is at full scale and also far from the reference of the other parity. The second is a qualifier-low cycle that carries index 14 in the middle of a line. The stimulus drives three complete lines: one with references close together, one with the odd reference at full scale and the even reference at zero, and one with the odd reference below the even one. The full-scale line forces saturation on every odd pixel and gives the largest positive difference. The third line gives a negative difference. Idle cycles that carry index 14 and a large sample are inserted all through each line, so any qualifier leak would show up at once in the reference outputs.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
   // lsb of a 1-based pixel position: 1 = odd, 0 = even
   function automatic logic pos_lsb(input int pos);
      return (pos % 2) == 1;
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/clamp_ref_acc.sv
module clamp_ref_acc #(
   parameter int DATA_W    = 12,
   parameter int IDX_W     = 12,
   parameter int FIRST_POS = 7,
   parameter int COUNT     = 4,
   parameter int LATCH_POS = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [IDX_W-1:0]  in_index,
   input  logic [DATA_W-1:0] in_sample,
   output logic [DATA_W-1:0] ref_o
);
   localparam int SH       = $clog2(COUNT);
   localparam int SUM_W    = DATA_W + SH;
   localparam int LAST_POS = FIRST_POS + 2 * (COUNT - 1);
   localparam logic PAR    = clamp_pkg::pos_lsb(FIRST_POS);

   logic [SUM_W-1:0] sum_q, sum_nxt, src;
   logic hit, start, latch;

   assign hit   = in_valid && (in_index >= IDX_W'(FIRST_POS)) &&
                  (in_index <= IDX_W'(LAST_POS)) && (in_index[0] == PAR);
   assign start = in_valid && (in_index == IDX_W'(FIRST_POS));
   assign latch = in_valid && (in_index == IDX_W'(LATCH_POS));
   assign sum_nxt = (start ? '0 : sum_q) + SUM_W'(in_sample);
   assign src     = hit ? sum_nxt : sum_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q <= '0;
         ref_o <= '0;
      end else begin
         if (hit)   sum_q <= sum_nxt;
         if (latch) ref_o <= DATA_W'(src >> SH);
      end
   end

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch |=> $stable(ref_o));
endmodule

// File: rtl/clamp_sub.sv
module clamp_sub #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              v_i,
   input  logic [DATA_W-1:0] d_i,
   input  logic [DATA_W-1:0] ref_i,
   output logic              v_o,
   output logic [DATA_W-1:0] q_o
);
   logic below;
   assign below = d_i < ref_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_o <= 1'b0;
         q_o <= '0;
      end else begin
         v_o <= v_i;
         if (v_i) q_o <= below ? '0 : d_i - ref_i;
      end
   end

   // R7
   sat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && below) |=> (v_o && q_o == '0));
   // R6
   pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && !below) |=> (DATA_W'(q_o + $past(ref_i)) == $past(d_i)));
endmodule

// File: rtl/parity_black_clamp.sv
module parity_black_clamp #(
   parameter int DATA_W    = 12,
   parameter int IDX_W     = 12,
   parameter int NUM_LEAD  = 98,
   parameter int NUM_EFF   = 3918,
   parameter int REF_FIRST = 7,
   parameter int REF_COUNT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [IDX_W-1:0]  in_index,
   input  logic [DATA_W-1:0] in_sample,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_pixel,
   output logic [DATA_W-1:0] black_odd,
   output logic [DATA_W-1:0] black_even,
   output logic [DATA_W:0]   black_diff
);
   localparam int EFF_LO    = NUM_LEAD + 1;
   localparam int EFF_HI    = NUM_LEAD + NUM_EFF;
   localparam int LATCH_POS = REF_FIRST + 2 * REF_COUNT - 1;

   initial begin
      if (!clamp_pkg::is_pow2(REF_COUNT))
         $error("REF_COUNT must be a power of two");
      if (EFF_HI >= (1 << IDX_W))
         $error("IDX_W too narrow for the line");
      if (LATCH_POS >= EFF_LO)
         $error("reference pixels must precede effective pixels");
   end

   logic [DATA_W-1:0] ref_by_lsb [2];
   logic eff;

   for (genvar g = 0; g < 2; g++) begin : g_par
      localparam int FP = REF_FIRST + g;
      clamp_ref_acc #(
         .DATA_W(DATA_W), .IDX_W(IDX_W), .FIRST_POS(FP),
         .COUNT(REF_COUNT), .LATCH_POS(LATCH_POS)
      ) u_acc (
         .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
         .in_index(in_index), .in_sample(in_sample),
         .ref_o(ref_by_lsb[clamp_pkg::pos_lsb(FP)])
      );
   end

   assign eff = in_valid && (in_index >= IDX_W'(EFF_LO)) &&
                (in_index <= IDX_W'(EFF_HI));

   clamp_sub #(.DATA_W(DATA_W)) u_sub (
      .clk(clk), .rst_n(rst_n), .v_i(eff), .d_i(in_sample),
      .ref_i(ref_by_lsb[in_index[0]]), .v_o(out_valid), .q_o(out_pixel)
   );

   assign black_odd  = ref_by_lsb[1];
   assign black_even = ref_by_lsb[0];
   assign black_diff = {1'b0, black_odd} - {1'b0, black_even};

   // R8
   drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eff |=> !out_valid);
   // R5
   diff_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (black_odd >= black_even) == !black_diff[DATA_W]);
endmodule

// File: tb/sim_parity_black_clamp.sv
module sim_parity_black_clamp;
   localparam int DW = 12;
   localparam int IW = 12;
   localparam int LINE = 4034;

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
   logic [IW-1:0] in_index = '0;
   logic [DW-1:0] in_sample = '0;
   logic out_valid;
   logic [DW-1:0] out_pixel, black_odd, black_even;
   logic [DW:0] black_diff;

   int total = 0, bad = 0;
   bit exp_v = 0;
   int exp_d = 0, exp_ro = 0, exp_re = 0, so = 0, se = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   parity_black_clamp u0 (.*);

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic step(input bit v, input int idx, input int d);
      int r;
      @(negedge clk);
      chk(exp_v ? "R6 valid" : "R8 valid", int'(out_valid), int'(exp_v));
      if (exp_v) chk(exp_d == 0 ? "R7 pixel" : "R6 pixel", int'(out_pixel), exp_d);
      chk("R3/R4/R9 odd ref", int'(black_odd), exp_ro);
      chk("R2/R4/R9 even ref", int'(black_even), exp_re);
      chk("R5 diff", int'($signed(black_diff)), exp_ro - exp_re);
      in_valid = v; in_index = IW'(idx); in_sample = DW'(d);
      exp_v = v && idx >= 99 && idx <= 4016;
      if (exp_v) begin
         r = (idx % 2 == 1) ? exp_ro : exp_re;
         exp_d = (d < r) ? 0 : d - r;
      end
      if (v) begin
         if (idx == 7) so = d;
         if (idx == 9 || idx == 11 || idx == 13) so += d;
         if (idx == 8) se = d;
         if (idx == 10 || idx == 12 || idx == 14) se += d;
         if (idx == 14) begin exp_ro = so / 4; exp_re = se / 4; end
      end
   endtask

   task automatic run_line(input int ln, input int o[4], input int e[4]);
      int d;
      for (int i = 1; i <= LINE; i++) begin
         if (i % 97 == 0) step(1'b0, 14, 4000);  // R9 idle with index 14
         if (i >= 7 && i <= 14)
            d = (i % 2 == 1) ? o[(i - 7) / 2] : e[(i - 8) / 2];
         else
            d = (i * 37 + ln * 613) % 4096;
         step(1'b1, i, d);
      end
      step(1'b0, 14, 4095);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 valid", int'(out_valid), 0);
      chk("R1 pixel", int'(out_pixel), 0);
      chk("R1 odd", int'(black_odd), 0);
      chk("R1 even", int'(black_even), 0);
      chk("R1 diff", int'(black_diff), 0);
      rst_n = 1'b1;
      run_line(0, '{100, 101, 102, 104}, '{200, 201, 202, 203});
      run_line(1, '{4095, 4095, 4095, 4095}, '{0, 0, 0, 0});
      run_line(2, '{10, 20, 30, 40}, '{300, 300, 301, 302});
      step(1'b0, 0, 0);
      step(1'b0, 0, 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog R6 act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule